// File: doc/BRIEF.md
# Pipelined Converter Digital Correction Backend

This block sits behind the analog core of one channel of a nine-stage pipelined converter. Stages 0 to 7 each resolve 1.5 bits and hand over a three-valued decision. The final stage is a plain 2-bit flash. A sample moves one stage forward every half clock, so its decisions reach the digital side spread over five clock cycles. The block delays each decision so that all nine line up. It then sums them with overlapping binary weights, which lets the redundancy cancel comparator offsets. Finally it registers a 10-bit word in the selected number format.

Stage decisions are grouped in pairs. Stage i belongs to group i/2 (integer division), because the odd stage of a pair resolves on the falling edge inside the same cycle. The group-g codes of a sample are presented during the cycle that follows the (g+1)-th rising edge counted from, and including, the sampling edge. The corrected word then appears five active edges after sampling. While power-down is high the block keeps its output word and freezes its pipeline. After wake-up, the valid strobe stays low until a freshly sampled word reaches the output.

Top module: `adc_corr_backend`

## Requirements
- R1: A sample taken at an active rising edge (one where pwr_dn is low) appears on dout after the fifth active edge that follows it. Its stage-i code is read during the cycle after the (i/2+1)-th active edge counted from the sampling edge.
- R2: Each stage code is a 2-bit binary number in bits [2i+1:2i] of stage_code. Stage 0 sits in the lowest bits. Stages 0 to 7 carry 0..2 and stage 8 carries 0..3. The corrected value is the sum over i of code_i * 2^(8-i). So when an ideal quantiser feeds the stages and each comparator threshold is off by up to a quarter of its stage weight, the output equals the ideal 10-bit value for all 1024 codes.
- R3: A sum above 1023 is clamped to 1023. Such a sum only arises from the illegal code 3 in stages 0 to 7. Analog inputs above or below full scale produce 1023 or 0.
- R4: When tc_sel is low, dout is offset binary. When tc_sel is high, dout is the same word with bit 9 inverted, which is two's complement. tc_sel is taken at the same edge as the data it formats.
- R5: At any rising edge with pwr_dn high, dout keeps its value and the alignment pipeline does not advance.
- R6: dvalid is low at every edge with pwr_dn high. After reset or wake-up it rises at the sixth consecutive active edge and stays high while pwr_dn stays low.
- R7: drv_en follows out_en within the same cycle. out_en has no effect on the value of dout.
- R8: While rst_n is low, dout is 0 and dvalid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; rising edge samples and advances |
| rst_n | input | 1 | Asynchronous active-low reset |
| stage_code | input | 18 | Nine 2-bit stage decisions, stage 0 in bits [1:0] |
| tc_sel | input | 1 | Output format: 0 offset binary, 1 two's complement |
| out_en | input | 1 | Output enable for the external tri-state pad |
| pwr_dn | input | 1 | Power-down: hold output, freeze pipeline |
| dout | output | 10 | Registered corrected sample |
| dvalid | output | 1 | High when dout carries a freshly sampled word |
| drv_en | output | 1 | Tri-state enable for the data pads |

## Verification
A delay line of the wrong depth for any group mixes decisions from neighbouring samples. On a monotonic sweep this shows as a wrong word starting with the first valid output, five active edges after the first sample. A wrong stage weight or a missing clamp shows up as soon as the sweep crosses that stage's decision threshold, or as soon as an over-range or illegal code appears. A power-down that lets the pipeline or the output register advance corrupts the held word at the very next edge. A warm-up counter that is off by one moves the rising edge of dvalid by one cycle after reset or wake-up.

// File: rtl/adc_corr_pkg.sv
`timescale 1ns/1ps
package adc_corr_pkg;
  // width of one stage decision
  localparam int CODE_W = 2;

  typedef enum logic {
    FMT_OFFSET = 1'b0,
    FMT_TWOS   = 1'b1
  } fmt_e;
endpackage

// File: rtl/corr_align.sv
`timescale 1ns/1ps
module corr_align
  import adc_corr_pkg::*;
#(
  parameter int NSTAGE = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     adv,
  input  logic [NSTAGE*CODE_W-1:0] codes_in,
  output logic [NSTAGE*CODE_W-1:0] codes_aligned
);
  localparam int NGRP = (NSTAGE + 1) / 2;

  // stage i arrives i/2 cycles late, so it needs NGRP-1-i/2 cycles of delay
  for (genvar i = 0; i < NSTAGE; i++) begin : g_stg
    localparam int DEPTH = NGRP - 1 - i / 2;
    if (DEPTH == 0) begin : g_pass
      assign codes_aligned[i*CODE_W +: CODE_W] = codes_in[i*CODE_W +: CODE_W];
    end else begin : g_dly
      logic [CODE_W-1:0] sr [DEPTH];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int k = 0; k < DEPTH; k++) sr[k] <= '0;
        end else if (adv) begin
          sr[0] <= codes_in[i*CODE_W +: CODE_W];
          for (int k = 1; k < DEPTH; k++) sr[k] <= sr[k-1];
        end
      end
      assign codes_aligned[i*CODE_W +: CODE_W] = sr[DEPTH-1];
    end
  end
endmodule

// File: rtl/corr_sum.sv
`timescale 1ns/1ps
module corr_sum
  import adc_corr_pkg::*;
#(
  parameter int NSTAGE = 9
) (
  input  logic [NSTAGE*CODE_W-1:0] codes,
  output logic [NSTAGE:0]          sum,
  output logic                     ovf
);
  localparam int OUT_W = NSTAGE + 1;
  localparam int SUM_W = NSTAGE + 2;
  localparam logic [SUM_W-1:0] MAXC = SUM_W'((1 << OUT_W) - 1);

  // overlapping binary weights: stage i counts 2^(NSTAGE-1-i)
  function automatic logic [SUM_W-1:0] weigh(input logic [NSTAGE*CODE_W-1:0] c);
    logic [SUM_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < NSTAGE; i++)
      acc = acc + (SUM_W'(c[i*CODE_W +: CODE_W]) << (NSTAGE - 1 - i));
    return acc;
  endfunction

  logic [SUM_W-1:0] raw;
  assign raw = weigh(codes);
  assign ovf = (raw > MAXC);
  assign sum = ovf ? '1 : raw[OUT_W-1:0];
endmodule

// File: rtl/corr_out.sv
`timescale 1ns/1ps
module corr_out
  import adc_corr_pkg::*;
#(
  parameter int OUT_W = 10,
  parameter int LAT   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_dn,
  input  logic             tc_sel,
  input  logic [OUT_W-1:0] sum,
  output logic [OUT_W-1:0] dout,
  output logic             dvalid
);
  localparam int CNT_W = $clog2(LAT + 1);

  function automatic logic [OUT_W-1:0] fmt(input logic [OUT_W-1:0] v, input fmt_e f);
    return (f == FMT_TWOS) ? {~v[OUT_W-1], v[OUT_W-2:0]} : v;
  endfunction

  fmt_e             fsel;
  logic             upd;
  logic [CNT_W-1:0] warm;

  assign fsel = fmt_e'(tc_sel);
  assign upd  = !pwr_dn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout   <= '0;
      dvalid <= 1'b0;
      warm   <= '0;
    end else if (!upd) begin
      dvalid <= 1'b0;
      warm   <= '0;
    end else begin
      dout   <= fmt(sum, fsel);
      dvalid <= (warm == CNT_W'(LAT));
      if (warm != CNT_W'(LAT)) warm <= warm + 1'b1;
    end
  end

  // R5: output word frozen through a power-down edge
  p_hold_in_pd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> $stable(dout));
  // R6: valid drops on power-down
  p_valid_low_pd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> !dvalid);
  // R6: valid persists while powered
  p_valid_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dvalid && !pwr_dn) |=> dvalid);
  // R4: low bits pass, top bit follows format
  p_fmt_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> dout[OUT_W-2:0] == $past(sum[OUT_W-2:0]));
  p_fmt_msb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> dout[OUT_W-1] == ($past(sum[OUT_W-1]) ^ $past(tc_sel)));
endmodule

// File: rtl/adc_corr_backend.sv
`timescale 1ns/1ps
module adc_corr_backend
  import adc_corr_pkg::*;
#(
  parameter int NSTAGE = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSTAGE*CODE_W-1:0] stage_code,
  input  logic                     tc_sel,
  input  logic                     out_en,
  input  logic                     pwr_dn,
  output logic [NSTAGE:0]          dout,
  output logic                     dvalid,
  output logic                     drv_en
);
  localparam int OUT_W = NSTAGE + 1;
  localparam int LAT   = (NSTAGE + 1) / 2;

  logic [NSTAGE*CODE_W-1:0] codes_aligned;
  logic [OUT_W-1:0]         sum;
  logic                     sum_ovf;

  corr_align #(.NSTAGE(NSTAGE)) u_align (
    .clk(clk), .rst_n(rst_n), .adv(!pwr_dn),
    .codes_in(stage_code), .codes_aligned(codes_aligned)
  );

  corr_sum #(.NSTAGE(NSTAGE)) u_sum (
    .codes(codes_aligned), .sum(sum), .ovf(sum_ovf)
  );

  corr_out #(.OUT_W(OUT_W), .LAT(LAT)) u_out (
    .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .tc_sel(tc_sel),
    .sum(sum), .dout(dout), .dvalid(dvalid)
  );

  assign drv_en = out_en;

  // R3: an overflowing sum reaches the output as full scale
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_ovf && !pwr_dn) |=> (dout[OUT_W-2:0] == '1) && (dout[OUT_W-1] == !$past(tc_sel)));
endmodule

// File: tb/adc_corr_backend_test.sv
`timescale 1ns/1ps
module adc_corr_backend_test;
  localparam int NS   = 9;
  localparam int OW   = 10;
  localparam int NX   = 2048;
  localparam int ILL  = 99999;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst_n, tc_sel, out_en, pwr_dn;
  logic [2*NS-1:0] stage_code;
  logic [OW-1:0]   dout;
  logic            dvalid, drv_en;

  adc_corr_backend uut (
    .clk(clk), .rst_n(rst_n), .stage_code(stage_code), .tc_sel(tc_sel),
    .out_en(out_en), .pwr_dn(pwr_dn), .dout(dout), .dvalid(dvalid), .drv_en(drv_en)
  );

  int errors = 0, checks = 0;
  int xs [NX];
  int A = 0, warm = 0;
  int held = 0;
  logic pd_at, tc_at;
  bit done = 0;

  // behavioural analog pipeline with comparator offsets of a quarter weight
  function automatic logic [2*NS-1:0] enc(input int x);
    logic [2*NS-1:0] c;
    int r, w, o1, d;
    if (x == ILL) return '1;
    c = '0; r = x;
    for (int i = 0; i < NS-1; i++) begin
      w  = 1 << (NS-1-i);
      o1 = (i % 2 == 0) ? w/4 : -(w/4);
      d = 0;
      if (2*r >= 3*w + 2*o1) d++;
      if (2*r >= 5*w - 2*o1) d++;
      c[2*i +: 2] = 2'(d);
      r = r - d*w;
    end
    c[2*(NS-1) +: 2] = (r < 0) ? 2'd0 : (r > 3) ? 2'd3 : 2'(r);
    return c;
  endfunction

  function automatic int ideal(input int x, input logic tc);
    int e;
    e = (x == ILL) ? 1023 : (x < 0) ? 0 : (x > 1023) ? 1023 : x;
    return tc ? (e ^ 512) : e;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive();
    for (int i = 0; i < NS; i++) begin
      int idx;
      logic [2*NS-1:0] c;
      idx = A - 1 - i/2;   // R1: group i/2 lags by i/2 cycles
      c = (idx >= 0 && idx < NX) ? enc(xs[idx]) : '0;
      stage_code[2*i +: 2] = c[2*i +: 2];
    end
  endtask

  task automatic tick();
    int x;
    @(posedge clk);
    pd_at = pwr_dn; tc_at = tc_sel;
    if (rst_n) begin
      if (!pd_at) begin A++; warm++; end
      else warm = 0;
    end
    @(negedge clk);
    if (rst_n) begin
      chk("R6 valid strobe", int'(dvalid), int'(warm >= 6));
      if (pd_at) chk("R5 hold in power-down", int'(dout), held);
      else if (warm >= 6 && A-6 < NX) begin
        x = xs[A-6];
        if (x == ILL || x < 0 || x > 1023)
          chk("R3 saturation", int'(dout), ideal(x, tc_at));
        else if (tc_at)
          chk("R4 R1 R2 two's complement word", int'(dout), ideal(x, tc_at));
        else
          chk("R1 R2 offset binary word", int'(dout), ideal(x, tc_at));
      end
    end
    held = int'(dout);
    drive();
  endtask

  initial begin
    for (int i = 0; i < NX; i++) begin
      if (i < 1024) xs[i] = i;
      else begin
        case (i - 1024)
          0: xs[i] = -1;     1: xs[i] = -40;   2: xs[i] = 1024;
          3: xs[i] = 1025;   4: xs[i] = 2000;  5: xs[i] = ILL;
          6: xs[i] = ILL;    7: xs[i] = 0;     8: xs[i] = 1023;
          9: xs[i] = 512;    10: xs[i] = 511;
          default: xs[i] = (i*389 + 17) % 1100 - 40;
        endcase
      end
    end
    rst_n = 1'b0; pwr_dn = 1'b0; tc_sel = 1'b0; out_en = 1'b1; stage_code = '0;
    repeat (3) @(negedge clk);
    chk("R8 reset dout", int'(dout), 0);
    chk("R8 reset dvalid", int'(dvalid), 0);
    held = 0;
    rst_n = 1'b1;
    for (int t = 0; t < 1500; t++) begin
      tc_sel = ((t / 97) % 2) == 1;
      out_en = ((t / 50) % 3) != 0;
      pwr_dn = (t >= 1100 && t < 1104) || (t >= 1300 && t < 1310);
      #1;
      chk("R7 drv_en follows out_en", int'(drv_en), int'(out_en));
      tick();
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule